// File: doc/BRIEF.md
# Tick-Driven Clock Interrupt Emulator

This block rebuilds the three interrupt sources of a legacy real-time clock from one fixed polling tick, nominally 64 Hz, which a timer comparator elsewhere supplies as a single-cycle pulse. On each tick it can raise up to three flags. The update flag marks a change of the seconds value. The alarm flag marks a match of hour, minute and second against a stored alarm time. The periodic flag comes from a programmable tick divider.

The block reads the current time fields from an external calendar and the alarm time from its own inputs. It has one enable per source. The periodic divisor is given as a count of base ticks, 64 divided by the wanted rate, so slow rates of 2 Hz to 64 Hz become divisors of 32 down to 1. A lost-tick count reports base ticks that were skipped while the comparator was being moved ahead of the counter, and these are credited to the periodic divider.

Whenever a tick raises at least one flag, the block emits a status word with a one-cycle valid strobe. A timer-request output tells the comparator logic whether ticks are still needed.

Top module: `rtc_tick_emu`

## Requirements
- R1: A divisor of 1 raises the periodic flag on every tick. A divisor of 32, which is the 2 Hz rate, raises it on every 32nd tick.
- R2: The periodic counter adds one per tick. The flag fires on the tick where the count reaches the divisor, and the counter then restarts from zero.
- R3: With updates enabled, the update flag fires on a tick whose seconds value differs from the value seen on the previous tick. An unchanged second raises nothing.
- R4: While updates are disabled, the stored previous second is invalid. The first tick after enabling records the second without raising the update flag.
- R5: With the alarm enabled, the alarm flag fires on a tick where hour, minute and second all equal the alarm inputs. A mismatch in any one field raises nothing.
- R6: The status word places the flags as follows: update in bit 4, alarm in bit 5, periodic in bit 6. Bit 7 is an interrupt-pending bit that is set whenever any flag is set. Bits 15:8 hold an interrupt count of 1, and bits 3:0 are zero.
- R7: The lost-tick count present on a tick is added to the periodic counter on top of that tick's own increment.
- R8: `timer_req` is the registered OR of the three source enables. It is low one cycle after all three are cleared.
- R9: Flags from several sources on the same tick are combined into a single status word.
- R10: `stat_valid` is high only in the cycle after a tick that raised at least one flag. No cycle without a tick produces it.
- R11: While the periodic source is disabled, its counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base polling tick, one cycle wide |
| cur_hour | input | 5 | Current hour |
| cur_min | input | 6 | Current minute |
| cur_sec | input | 6 | Current second |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| en_update | input | 1 | Enable for the update source |
| en_alarm | input | 1 | Enable for the alarm source |
| en_periodic | input | 1 | Enable for the periodic source |
| per_div | input | DIV_W | Periodic divisor, in base ticks per event |
| lost_ticks | input | LOST_W | Ticks missed before this tick |
| stat_word | output | 16 | Status word |
| stat_valid | output | 1 | One-cycle strobe that qualifies `stat_word` |
| timer_req | output | 1 | Ticks are still needed |

## Verification
Two situations are hard to reach from the ports. The first is lost-tick crediting, where the periodic event must fire earlier than the plain divisor allows. The bench reaches it by presenting a nonzero lost count on one tick and a zero count on the ticks that follow, so the tick on which the event fires is known exactly. The second is first-update suppression, which can only be seen by toggling the update enable between ticks and then confirming that a changed second is still not flagged on the first tick after the enable returns.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;

    localparam int WORD_W   = 16;
    localparam int HOUR_W   = 5;
    localparam int MIN_W    = 6;
    localparam int SEC_W    = 6;

    localparam int BIT_UPD  = 4;
    localparam int BIT_ALM  = 5;
    localparam int BIT_PER  = 6;
    localparam int BIT_PEND = 7;
    localparam logic [7:0] IRQ_COUNT = 8'd1;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_flags_t;

    function automatic logic [WORD_W-1:0] pack_status(input src_flags_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_UPD]  = f.upd;
        w[BIT_ALM]  = f.alm;
        w[BIT_PER]  = f.per;
        w[BIT_PEND] = f.upd | f.alm | f.per;
        w[15:8]     = IRQ_COUNT;
        return w;
    endfunction

endpackage

// File: rtl/rtc_upd_detect.sv
module rtc_upd_detect
    import rtc_emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic [SEC_W-1:0] sec,
    output logic             fire
);
    logic [SEC_W-1:0] last_sec;
    logic             last_ok;

    assign fire = tick && enable && last_ok && (sec != last_sec);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sec <= '0;
            last_ok  <= 1'b0;
        end else if (!enable) begin
            last_ok  <= 1'b0;
        end else if (tick) begin
            last_sec <= sec;
            last_ok  <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_emu_pkg::*;
(
    input  logic              tick,
    input  logic              enable,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [HOUR_W-1:0] alm_hour,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [SEC_W-1:0]  alm_sec,
    output logic              fire
);
    logic hit;

    always_comb begin
        hit = (cur_hour == alm_hour) && (cur_min == alm_min) && (cur_sec == alm_sec);
    end

    assign fire = tick && enable && hit;
endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
    parameter int DIV_W  = 8,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [LOST_W-1:0] lost,
    output logic              fire
);
    localparam int WIDE  = (DIV_W > LOST_W) ? DIV_W : LOST_W;
    localparam int ACC_W = WIDE + 2;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             reach;

    always_comb begin
        acc_sum = acc + ACC_W'(lost) + ACC_W'(1);
        reach   = acc_sum >= ACC_W'(divisor);
    end

    assign fire = tick && enable && reach;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            acc <= '0;
        end else if (tick) begin
            acc <= reach ? '0 : acc_sum;
        end
    end
endmodule

// File: rtl/rtc_tick_emu.sv
module rtc_tick_emu
    import rtc_emu_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [4:0]        cur_hour,
    input  logic [5:0]        cur_min,
    input  logic [5:0]        cur_sec,
    input  logic [4:0]        alm_hour,
    input  logic [5:0]        alm_min,
    input  logic [5:0]        alm_sec,
    input  logic              en_update,
    input  logic              en_alarm,
    input  logic              en_periodic,
    input  logic [DIV_W-1:0]  per_div,
    input  logic [LOST_W-1:0] lost_ticks,
    output logic [15:0]       stat_word,
    output logic              stat_valid,
    output logic              timer_req
);
    src_flags_t flags;

    rtc_upd_detect u_upd (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .enable (en_update),
        .sec    (cur_sec),
        .fire   (flags.upd)
    );

    rtc_alarm_match u_alm (
        .tick     (tick),
        .enable   (en_alarm),
        .cur_hour (cur_hour),
        .cur_min  (cur_min),
        .cur_sec  (cur_sec),
        .alm_hour (alm_hour),
        .alm_min  (alm_min),
        .alm_sec  (alm_sec),
        .fire     (flags.alm)
    );

    rtc_periodic_div #(.DIV_W(DIV_W), .LOST_W(LOST_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .enable  (en_periodic),
        .divisor (per_div),
        .lost    (lost_ticks),
        .fire    (flags.per)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_word  <= '0;
            stat_valid <= 1'b0;
            timer_req  <= 1'b0;
        end else begin
            timer_req  <= en_update | en_alarm | en_periodic;
            stat_valid <= |flags;
            if (|flags) begin
                stat_word <= pack_status(flags);
            end
        end
    end
endmodule

// File: rtl/rtc_tick_emu_chk.sv
module rtc_tick_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        en_update,
    input logic        en_alarm,
    input logic        en_periodic,
    input logic [15:0] stat_word,
    input logic        stat_valid,
    input logic        timer_req
);
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !stat_valid); // R10

    AST_PEND_AND_COUNT: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_word[7] && stat_word[15:8] == 8'd1 && stat_word[3:0] == 4'd0)); // R6

    AST_SOURCE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (stat_word[6:4] != 3'b000)); // R9

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!en_update && !en_alarm && !en_periodic) |=> !timer_req); // R8

    AST_REQ_RISES: assert property (@(posedge clk) disable iff (rst)
        en_periodic |=> timer_req); // R8
endmodule

bind rtc_tick_emu rtc_tick_emu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .en_update   (en_update),
    .en_alarm    (en_alarm),
    .en_periodic (en_periodic),
    .stat_word   (stat_word),
    .stat_valid  (stat_valid),
    .timer_req   (timer_req)
);

// File: tb/tb_rtc_tick_emu.sv
module tb_rtc_tick_emu;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [4:0]  cur_hour, alm_hour;
    logic [5:0]  cur_min, cur_sec, alm_min, alm_sec;
    logic        en_update, en_alarm, en_periodic;
    logic [7:0]  per_div, lost_ticks;
    logic [15:0] stat_word;
    logic        stat_valid, timer_req;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rtc_tick_emu dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
        .per_div(per_div), .lost_ticks(lost_ticks),
        .stat_word(stat_word), .stat_valid(stat_valid), .timer_req(timer_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One tick pulse; result sampled after the registering edge.
    task automatic pulse(output logic v, output logic [15:0] w);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        v = stat_valid;
        w = stat_word;
    endtask

    task automatic expect_none(input string req);
        logic v; logic [15:0] w;
        pulse(v, w);
        check(req, {31'd0, v}, 32'd0);
    endtask

    task automatic expect_word(input string req, input logic [15:0] exp);
        logic v; logic [15:0] w;
        pulse(v, w);
        check(req, {31'd0, v}, 32'd1);
        check(req, {16'd0, w}, {16'd0, exp});
        @(negedge clk);
        check({req, " strobe one cycle"}, {31'd0, stat_valid}, 32'd0);
    endtask

    task automatic all_off();
        @(negedge clk);
        en_update = 0; en_alarm = 0; en_periodic = 0; lost_ticks = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 reset valid", {31'd0, stat_valid}, 32'd0);
        check("R8 reset req", {31'd0, timer_req}, 32'd0);
        @(negedge clk) en_periodic = 1;
        @(negedge clk);
        check("R8 req high", {31'd0, timer_req}, 32'd1);
        all_off();
    endtask

    task automatic t_update();
        @(negedge clk) en_update = 1; cur_sec = 6'd5;
        expect_none("R4 first second suppressed");
        expect_none("R3 same second");
        cur_sec = 6'd6;
        expect_word("R3 R6 update", 16'h0190);
        @(negedge clk) en_update = 0;
        @(negedge clk) en_update = 1; cur_sec = 6'd7;
        expect_none("R4 re-enable suppressed");
        cur_sec = 6'd8;
        expect_word("R3 after re-enable", 16'h0190);
        all_off();
    endtask

    task automatic t_alarm();
        alm_hour = 5'd1; alm_min = 6'd2; alm_sec = 6'd3;
        cur_hour = 5'd1; cur_min = 6'd9; cur_sec = 6'd3;
        @(negedge clk) en_alarm = 1;
        expect_none("R5 minute mismatch");
        cur_min = 6'd2; cur_hour = 5'd4;
        expect_none("R5 hour mismatch");
        cur_hour = 5'd1;
        expect_word("R5 R6 alarm match", 16'h01A0);
        all_off();
    endtask

    task automatic t_periodic();
        per_div = 8'd4;
        @(negedge clk) en_periodic = 1;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 3; i++) expect_none("R2 below divisor");
            expect_word("R2 R6 periodic", 16'h01C0);
        end
        per_div = 8'd1;
        expect_word("R1 divisor 1", 16'h01C0);
        expect_word("R1 divisor 1 again", 16'h01C0);
        per_div = 8'd32;
        for (int i = 0; i < 31; i++) expect_none("R1 2Hz wait");
        expect_word("R1 2Hz event", 16'h01C0);
        // R11: partial count discarded while disabled
        per_div = 8'd4;
        expect_none("R11 pre count 1");
        expect_none("R11 pre count 2");
        @(negedge clk) en_periodic = 0;
        @(negedge clk) en_periodic = 1;
        for (int i = 0; i < 3; i++) expect_none("R11 counter cleared");
        expect_word("R11 fires after full divisor", 16'h01C0);
        all_off();
    endtask

    task automatic t_lost();
        per_div = 8'd8; lost_ticks = 8'd5;
        @(negedge clk) en_periodic = 1;
        expect_none("R7 count 6");
        lost_ticks = 8'd0;
        expect_none("R7 count 7");
        expect_word("R7 count 8 fires", 16'h01C0);
        lost_ticks = 8'd9;
        expect_word("R7 lost beyond divisor", 16'h01C0);
        all_off();
    endtask

    task automatic t_combined();
        per_div = 8'd1;
        alm_hour = 5'd2; alm_min = 6'd3; alm_sec = 6'd4;
        cur_hour = 5'd2; cur_min = 6'd3; cur_sec = 6'd3;
        @(negedge clk) en_update = 1; en_alarm = 1; en_periodic = 1;
        expect_word("R9 periodic only", 16'h01C0);
        cur_sec = 6'd4;
        expect_word("R9 all three", 16'h01F0);
        all_off();
        check("R8 req low", {31'd0, timer_req}, 32'd0);
        cur_sec = 6'd4;
        expect_none("R10 disabled sources silent");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; tick = 0;
        cur_hour = 0; cur_min = 0; cur_sec = 0;
        alm_hour = 5'd31; alm_min = 6'd63; alm_sec = 6'd63;
        en_update = 0; en_alarm = 0; en_periodic = 0;
        per_div = 8'd4; lost_ticks = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_update();
        t_alarm();
        t_periodic();
        t_lost();
        t_combined();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule